// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block forms the effective address of a single-word memory-reference instruction for a 16-bit accumulator machine. The sequencer pulses `start_i` with the instruction word, the program counter, the index register and the current word/byte mode. The program counter must already point past the instruction. The block decodes a displacement, an indirect flag and a two-bit address mode from the instruction word. It then returns the address together with a byte-select flag and a one-cycle `done_o` strobe.

Direct addresses are computed in one cycle. When the indirect flag is set, the computed location holds a pointer. The block requests one word from a memory read port, holds the request until the memory answers with `rd_valid_i`, and returns the word it receives as the effective address. Indirection goes one level only. All arithmetic wraps modulo 2^16.

Top module: `ea_gen`

## Requirements
- R1: Field layout: displacement D is `instr_i[7:0]` (unsigned, 0 to 255), the indirect flag is `instr_i[8]`, and the mode is `instr_i[10:9]`. Bits 15:11 have no effect on any output.
- R2: Mode 00, direct: the effective address is D zero-extended, byte_sel is 0, and `done_o` is high in the cycle after `start_i`.
- R3: Mode 01, direct: the effective address is PC + D + 1 modulo 2^16 in both word and byte mode, with byte_sel 0.
- R4: Mode 10, direct: the effective address is D + X modulo 2^16 in both word and byte mode, with byte_sel 0.
- R5: Mode 11, direct, word mode: the effective address is PC − D modulo 2^16, with byte_sel 0.
- R6: Mode 11, direct, byte mode: the effective address is PC + D + 1 modulo 2^16, with byte_sel 1.
- R7: Indirect: in the cycle after start, `rd_req_o` goes high. `rd_addr_o` carries the pointer location, which is D, PC+D+1, D+X or PC−D for modes 00, 01, 10 and 11, in either word or byte mode. The request and the address hold until `rd_valid_i`.
- R8: Indirect completion: in the cycle after `rd_valid_i`, `done_o` is high, `ea_o` equals the sampled `rd_data_i`, byte_sel is 0 and `rd_req_o` is low.
- R9: `done_o` is a single-cycle pulse. `ea_o` and `byte_sel_o` hold their values until the next completion.
- R10: A `start_i` pulse received while an indirect fetch is pending is ignored.
- R11: Asynchronous active-low reset clears `done_o`, `rd_req_o`, `ea_o` and `byte_sel_o`, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin address generation (sampled when idle) |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter, already incremented |
| x_i | input | 16 | Index register |
| byte_mode_i | input | 1 | 1 = byte mode, 0 = word mode |
| rd_req_o | output | 1 | Pointer read request |
| rd_addr_o | output | 16 | Pointer read address |
| rd_data_i | input | 16 | Pointer read data |
| rd_valid_i | input | 1 | Read data valid |
| ea_o | output | 16 | Effective address |
| byte_sel_o | output | 1 | Byte select (1 = byte 1) |
| done_o | output | 1 | Address ready strobe |

## Verification
On every cycle, the assertions check the following:
- the single-cycle shape of `done_o`;
- the one-cycle latency of direct requests;
- that a pending read request and its address stay steady, including while a stray start arrives;
- that an indirect result equals the sampled read data, with byte select cleared.

Only the directed scenarios can show the address arithmetic of each mode against independently computed values. These include the wrap-around cases, the word/byte split of mode 11, the insensitivity to the upper instruction bits and the reset values.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    AM_ABS  = 2'b00,
    AM_FWD  = 2'b01,
    AM_IDX  = 2'b10,
    AM_BACK = 2'b11
  } amode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8,
  localparam int FIELD_W = DISP_W + 3
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  x_i,
  input  logic               byte_mode_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               ind_o,
  output logic               bsel_o
);
  logic [ADDR_W-1:0] d_ext, fwd, back;
  amode_e mode;

  assign d_ext = {{(ADDR_W-DISP_W){1'b0}}, field_i[DISP_W-1:0]};
  assign ind_o = field_i[DISP_W];
  assign mode  = amode_e'(field_i[DISP_W+2:DISP_W+1]);
  assign fwd   = pc_i + d_ext + ADDR_W'(1);
  assign back  = pc_i - d_ext;

  always_comb begin
    unique case (mode)
      AM_ABS:  addr_o = d_ext;
      AM_FWD:  addr_o = fwd;
      AM_IDX:  addr_o = d_ext + x_i;
      AM_BACK: addr_o = (byte_mode_i && !ind_o) ? fwd : back; // byte form only when direct
      default: addr_o = d_ext;
    endcase
  end

  assign bsel_o = byte_mode_i && !ind_o && (mode == AM_BACK);
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ind_i,
  input  logic              bsel_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              byte_sel_o,
  output logic              done_o
);
  ea_state_e         state_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      ea_o       <= '0;
      byte_sel_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ind_i) begin
            state_q <= ST_FETCH;
            ptr_q   <= addr_i;
          end else begin
            ea_o       <= addr_i;
            byte_sel_o <= bsel_i;
            done_o     <= 1'b1;
          end
        end
        ST_FETCH: if (rd_valid_i) begin
          ea_o       <= rd_data_i;
          byte_sel_o <= 1'b0;
          done_o     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == ST_FETCH);
  assign rd_addr_o = ptr_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DIRECT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !rd_req_o && !ind_i) |=> (done_o && ea_o == $past(addr_i))); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o) && !done_o)); // R7
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && start_i && !rd_valid_i) |=> ($stable(ea_o) && rd_req_o)); // R10
  AST_INDIRECT_EA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_valid_i) |=> (done_o && !rd_req_o && !byte_sel_o && ea_o == $past(rd_data_i))); // R8
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  x_i,
  input  logic               byte_mode_i,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [ADDR_W-1:0]  rd_data_i,
  input  logic               rd_valid_i,
  output logic [ADDR_W-1:0]  ea_o,
  output logic               byte_sel_o,
  output logic               done_o
);
  localparam int FIELD_W = DISP_W + 3;

  logic [ADDR_W-1:0] addr;
  logic              ind, bsel;
  logic              unused_hi;

  assign unused_hi = ^instr_i[INSTR_W-1:FIELD_W];

  ea_decode #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_decode (
    .field_i     (instr_i[FIELD_W-1:0]),
    .pc_i        (pc_i),
    .x_i         (x_i),
    .byte_mode_i (byte_mode_i),
    .addr_o      (addr),
    .ind_o       (ind),
    .bsel_o      (bsel)
  );

  ea_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .addr_i     (addr),
    .ind_i      (ind),
    .bsel_i     (bsel),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .rd_valid_i (rd_valid_i),
    .ea_o       (ea_o),
    .byte_sel_o (byte_sel_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] x_i = '0;
  logic        byte_mode_i = 1'b0;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic [15:0] rd_data_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [15:0] ea_o;
  logic        byte_sel_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  ea_gen i_ea_gen (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [4:0] hi, input logic [1:0] m,
                                     input logic ind, input logic [7:0] d);
    return {hi, m, ind, d};
  endfunction

  // direct request: done and result one cycle after start
  task automatic run_direct(input string req, input logic [15:0] ins, input logic [15:0] pc,
                            input logic [15:0] x, input logic bm,
                            input logic [15:0] exp_ea, input logic exp_bs);
    @(negedge clk_i);
    instr_i = ins; pc_i = pc; x_i = x; byte_mode_i = bm; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({req, " done"}, done_o, 1);
    check({req, " ea"}, ea_o, exp_ea);
    check({req, " byte_sel"}, byte_sel_o, exp_bs);
    check({req, " no req"}, rd_req_o, 0);
    @(negedge clk_i);
    check("R9 done pulse", done_o, 0);
    check("R9 ea held", ea_o, exp_ea);
  endtask

  task automatic run_indirect(input string req, input logic [15:0] ins, input logic [15:0] pc,
                              input logic [15:0] x, input logic bm,
                              input logic [15:0] exp_ptr, input logic [15:0] mem,
                              input int wait_cyc, input logic busy_start);
    logic [15:0] prev_ea;
    prev_ea = ea_o;
    @(negedge clk_i);
    instr_i = ins; pc_i = pc; x_i = x; byte_mode_i = bm; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({req, " rd_req"}, rd_req_o, 1);
    check({req, " rd_addr"}, rd_addr_o, exp_ptr);
    check({req, " no done"}, done_o, 0);
    for (int i = 0; i < wait_cyc; i++) begin
      if (busy_start && i == 0) begin
        instr_i = mk(5'd0, 2'b00, 1'b0, 8'h42); start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      check("R7 req held", rd_req_o, 1);
      check("R7 addr held", rd_addr_o, exp_ptr);
      if (busy_start) begin
        check("R10 busy start ignored done", done_o, 0);
        check("R10 busy start ignored ea", ea_o, prev_ea);
      end
    end
    rd_data_i = mem; rd_valid_i = 1'b1;
    @(negedge clk_i);
    rd_valid_i = 1'b0; rd_data_i = 16'hDEAD;
    check("R8 done", done_o, 1);
    check("R8 ea", ea_o, mem);
    check("R8 byte_sel", byte_sel_o, 0);
    check("R8 req drop", rd_req_o, 0);
    @(negedge clk_i);
    check("R9 done pulse", done_o, 0);
    check("R9 ea held", ea_o, mem);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R11 done", done_o, 0);
    check("R11 req", rd_req_o, 0);
    check("R11 ea", ea_o, 0);
    check("R11 byte_sel", byte_sel_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic test_direct_modes();
    run_direct("R2 abs", mk(5'd0, 2'b00, 1'b0, 8'hA5), 16'h1234, 16'h0100, 1'b0, 16'h00A5, 1'b0);
    run_direct("R2 abs byte", mk(5'd0, 2'b00, 1'b0, 8'hFF), 16'h1234, 16'h0100, 1'b1, 16'h00FF, 1'b0);
    run_direct("R3 fwd", mk(5'd0, 2'b01, 1'b0, 8'h10), 16'h2000, 16'h0, 1'b0, 16'h2011, 1'b0);
    run_direct("R3 fwd wrap byte", mk(5'd0, 2'b01, 1'b0, 8'hFF), 16'hFFFF, 16'h0, 1'b1, 16'h00FF, 1'b0);
    run_direct("R4 idx", mk(5'd0, 2'b10, 1'b0, 8'h05), 16'h0, 16'h0300, 1'b0, 16'h0305, 1'b0);
    run_direct("R4 idx wrap byte", mk(5'd0, 2'b10, 1'b0, 8'h20), 16'h0, 16'hFFF0, 1'b1, 16'h0010, 1'b0);
    run_direct("R5 back", mk(5'd0, 2'b11, 1'b0, 8'h05), 16'h0003, 16'h0, 1'b0, 16'hFFFE, 1'b0);
    run_direct("R5 back zero", mk(5'd0, 2'b11, 1'b0, 8'h00), 16'h4000, 16'h0, 1'b0, 16'h4000, 1'b0);
    run_direct("R6 back byte", mk(5'd0, 2'b11, 1'b0, 8'h05), 16'h0003, 16'h0, 1'b1, 16'h0009, 1'b1);
  endtask

  task automatic test_upper_bits();
    run_direct("R1 upper bits", mk(5'h1F, 2'b10, 1'b0, 8'h01), 16'h0, 16'h0010, 1'b0, 16'h0011, 1'b0);
    run_direct("R1 upper bits byte", mk(5'h15, 2'b11, 1'b0, 8'h02), 16'h0100, 16'h0, 1'b1, 16'h0103, 1'b1);
  endtask

  task automatic test_indirect();
    run_indirect("R7 abs", mk(5'd0, 2'b00, 1'b1, 8'h80), 16'h5000, 16'h0, 1'b0, 16'h0080, 16'hBEEF, 0, 1'b0);
    run_indirect("R7 fwd", mk(5'd0, 2'b01, 1'b1, 8'h02), 16'h5000, 16'h0, 1'b1, 16'h5003, 16'h1357, 3, 1'b0);
    run_indirect("R7 idx", mk(5'd0, 2'b10, 1'b1, 8'h02), 16'h0, 16'h7000, 1'b0, 16'h7002, 16'h0F0F, 1, 1'b0);
    run_indirect("R7 back byte", mk(5'd0, 2'b11, 1'b1, 8'h04), 16'h0010, 16'h0, 1'b1, 16'h000C, 16'hCAFE, 2, 1'b0);
  endtask

  task automatic test_busy_start();
    run_indirect("R10 busy", mk(5'd0, 2'b11, 1'b1, 8'h01), 16'h0200, 16'h0, 1'b0, 16'h01FF, 16'hA1A1, 4, 1'b1);
  endtask

  task automatic test_async_reset();
    @(negedge clk_i);
    instr_i = mk(5'd0, 2'b00, 1'b1, 8'h10); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    #3 rst_ni = 1'b0;
    #2;
    check("R11 async req", rd_req_o, 0);
    check("R11 async ea", ea_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_direct("R2 after reset", mk(5'd0, 2'b00, 1'b0, 8'h07), 16'h0, 16'h0, 1'b0, 16'h0007, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_direct_modes();
    test_upper_bits();
    test_indirect();
    test_busy_start();
    test_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule